// File: doc/BRIEF.md
# Display DMA Interrupt Status Unit

This block collects event pulses from a display controller's DMA channels and from its global control path, turns them into sticky status bits, and drives a single interrupt line. Channel 0 and the global events own fixed bits in a global status word. Channels 1 to 6 report start of frame, end of frame, branch taken and input underrun into a packed per-channel word. Bus errors also record the number of the failing channel. When a channel event is accepted while it is unmasked, the block raises a summary bit and captures that channel's frame ID word, so software can tell which descriptor produced the interrupt.

Software clears status by writing ones, and loads the two mask words through a small write port. Per-channel command words gate the frame events: a channel only reports start or end of frame when its current descriptor command asks for it. The interrupt output is a registered OR of every unmasked pending bit.

Top module: `disp_irq_status`

## Requirements
- R1: After synchronous reset both status words, both mask words, the captured frame ID and `irq_o` are all zero.
- R2: Global status bit positions: last frame done 0, channel 0 start of frame 1, bus error 2, bias count 3, underrun ch0 4, underrun ch1 5, output underrun 6, quick disable 7, channel 0 end of frame 8, channel 0 branch 9, summary 10, read status 11, command done 12.
- R3: For channel ch from 1 to 6 the channel status word takes start of frame at bit ch-1, end of frame at ch+7, branch at ch+15; underrun for ch from 2 to 6 takes bit ch+23; the channel mask word uses the same positions.
- R4: A start-of-frame pulse is recorded only when bit 22 of that channel's command word is one; an end-of-frame pulse only when bit 21 is one.
- R5: A bus error sets global bit 2 and writes the channel number into bits 30:28; with several in one cycle the highest channel number is kept.
- R6: An accepted channel event whose mask bit is clear sets the summary bit and loads that channel's frame ID; the highest such channel wins; a masked event sets only its own status bit.
- R7: A write with select 0 clears the global status bits that are one in data bits 11:0; writing bit 2 as one also clears bits 30:28; bit 12 is not cleared.
- R8: A write with select 1 clears channel status bits only where both the data and 0x003E3F3F are one.
- R9: A write with select 2 loads the global mask from data bits selected by 0x00001BFF; select 3 loads the channel mask from data bits selected by 0x3F3F3F3F.
- R10: `irq_o` is one clock after the state: the OR of global bits 12:0 except the summary bit, each ANDed with its clear mask bit, and of channel bits in 0x3F3F3F3F whose mask bit is clear.
- R11: A one-to-zero change on `ctl_enable` sets the quick-disable bit.
- R12: An event and a clearing write hitting the same bit in the same cycle leave the bit set.
- R13: Status bits stay set across idle cycles until cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_sof | input | NUM_CH | Start-of-frame pulse per channel |
| ev_eof | input | NUM_CH | End-of-frame pulse per channel |
| ev_branch | input | NUM_CH | Branch-taken pulse per channel |
| ev_buserr | input | NUM_CH | Bus error pulse per channel |
| ev_underrun | input | NUM_CH | Input underrun pulse per channel |
| ev_last_done | input | 1 | Last frame done pulse |
| ev_acb | input | 1 | Bias count pulse |
| ev_out_underrun | input | 1 | Output underrun pulse |
| ev_read_stat | input | 1 | Panel read status pulse |
| ev_cmd_done | input | 1 | Command done pulse |
| ctl_enable | input | 1 | Level of the controller enable control bit |
| ch_cmd | input | NUM_CH*32 | Current command word per channel, channel 0 in the low word |
| ch_frame_id | input | NUM_CH*ID_W | Current frame ID per channel, channel 0 in the low word |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 global status, 1 channel status, 2 global mask, 3 channel mask |
| wr_data | input | 32 | Write data |
| glb_status | output | 32 | Global status word |
| chn_status | output | 32 | Channel status word |
| int_id | output | ID_W | Captured frame ID |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The embedded properties watch, on every cycle, that pending status bits survive idle cycles, that an event always wins over a simultaneous clear, that a bus error lands with its channel code, that a channel-status write never touches bits outside its clear field, that the summary bit only rises with an unmasked channel event, and that the interrupt line never rises without pending state. The scenarios are needed for the exact bit placement of each event, the command-word gating, the choice of the highest channel when several report together, the clear-field limits, and the one-cycle lag of the interrupt after each change of status or mask.

// File: rtl/disp_isu_pkg.sv
package disp_isu_pkg;

    localparam int GW       = 32;
    localparam int CH_IDX_W = 3;

    // Global status bit positions
    localparam int B_LDD  = 0;
    localparam int B_SOF0 = 1;
    localparam int B_BER  = 2;
    localparam int B_ACB  = 3;
    localparam int B_UND0 = 4;
    localparam int B_UND1 = 5;
    localparam int B_OUT  = 6;
    localparam int B_QD   = 7;
    localparam int B_EOF0 = 8;
    localparam int B_BRA0 = 9;
    localparam int B_SUM  = 10;
    localparam int B_RDS  = 11;
    localparam int B_CMD  = 12;

    localparam int BERCH_LO = 28;

    // Command word gating bits
    localparam int CMD_EOF_EN = 21;
    localparam int CMD_SOF_EN = 22;

    localparam logic [GW-1:0] GCLR_MASK  = 32'h0000_0FFF;
    localparam logic [GW-1:0] CCLR_MASK  = 32'h003E_3F3F;
    localparam logic [GW-1:0] GIRQ_BITS  = 32'h0000_1BFF;
    localparam logic [GW-1:0] CVALID     = 32'h3F3F_3F3F;

    typedef enum logic [1:0] {
        SEL_GSTAT = 2'd0,
        SEL_CSTAT = 2'd1,
        SEL_GMASK = 2'd2,
        SEL_CMASK = 2'd3
    } isu_sel_e;

    typedef struct packed {
        logic [GW-1:0]       gset;
        logic [GW-1:0]       cset;
        logic                hit;
        logic [CH_IDX_W-1:0] hit_ch;
        logic                ber;
        logic [CH_IDX_W-1:0] ber_ch;
    } isu_upd_t;

    function automatic int sof_pos(input int ch);
        return ch - 1;
    endfunction

    function automatic int eof_pos(input int ch);
        return ch + 7;
    endfunction

    function automatic int bra_pos(input int ch);
        return ch + 15;
    endfunction

    function automatic int und_pos(input int ch);
        return ch + 23;
    endfunction

endpackage

// File: rtl/disp_isu_evmap.sv
module disp_isu_evmap
    import disp_isu_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int CMD_W  = 32
) (
    input  logic [NUM_CH-1:0]       ev_sof,
    input  logic [NUM_CH-1:0]       ev_eof,
    input  logic [NUM_CH-1:0]       ev_branch,
    input  logic [NUM_CH-1:0]       ev_buserr,
    input  logic [NUM_CH-1:0]       ev_underrun,
    input  logic                    ev_last_done,
    input  logic                    ev_acb,
    input  logic                    ev_out_underrun,
    input  logic                    ev_read_stat,
    input  logic                    ev_cmd_done,
    input  logic                    ev_quick_dis,
    input  logic [NUM_CH*CMD_W-1:0] ch_cmd,
    input  logic [GW-1:0]           gmask,
    input  logic [GW-1:0]           cmask,
    output isu_upd_t                upd
);

    logic [NUM_CH*GW-1:0] ch_g_flat;
    logic [NUM_CH*GW-1:0] ch_c_flat;
    logic [NUM_CH-1:0]    ch_hit;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
        logic          sof_ok;
        logic          eof_ok;
        logic [GW-1:0] gb;
        logic [GW-1:0] cb;

        assign sof_ok = ev_sof[gi] & ch_cmd[gi*CMD_W + CMD_SOF_EN];
        assign eof_ok = ev_eof[gi] & ch_cmd[gi*CMD_W + CMD_EOF_EN];

        if (gi == 0) begin : g_base
            always_comb begin
                gb         = '0;
                gb[B_SOF0] = sof_ok;
                gb[B_EOF0] = eof_ok;
                gb[B_BRA0] = ev_branch[gi];
                gb[B_UND0] = ev_underrun[gi];
                gb[B_BER]  = ev_buserr[gi];
                cb         = '0;
            end
        end else begin : g_packed
            localparam int P_SOF = sof_pos(gi);
            localparam int P_EOF = eof_pos(gi);
            localparam int P_BRA = bra_pos(gi);
            localparam int P_UND = und_pos(gi);
            always_comb begin
                gb         = '0;
                gb[B_BER]  = ev_buserr[gi];
                cb         = '0;
                cb[P_SOF]  = sof_ok;
                cb[P_EOF]  = eof_ok;
                cb[P_BRA]  = ev_branch[gi];
                if (gi == 1) begin
                    gb[B_UND1] = ev_underrun[gi];
                end else begin
                    cb[P_UND]  = ev_underrun[gi];
                end
            end
        end

        assign ch_g_flat[gi*GW +: GW] = gb;
        assign ch_c_flat[gi*GW +: GW] = cb;
        assign ch_hit[gi] = (|(gb & ~gmask & GIRQ_BITS)) | (|(cb & ~cmask & CVALID));
    end

    always_comb begin
        upd                 = '0;
        upd.gset[B_LDD]     = ev_last_done;
        upd.gset[B_ACB]     = ev_acb;
        upd.gset[B_OUT]     = ev_out_underrun;
        upd.gset[B_QD]      = ev_quick_dis;
        upd.gset[B_RDS]     = ev_read_stat;
        upd.gset[B_CMD]     = ev_cmd_done;
        // ascending scan: the highest channel number is the last writer
        for (int c = 0; c < NUM_CH; c++) begin
            upd.gset = upd.gset | ch_g_flat[c*GW +: GW];
            upd.cset = upd.cset | ch_c_flat[c*GW +: GW];
            if (ch_hit[c]) begin
                upd.hit    = 1'b1;
                upd.hit_ch = CH_IDX_W'(c);
            end
            if (ev_buserr[c]) begin
                upd.ber    = 1'b1;
                upd.ber_ch = CH_IDX_W'(c);
            end
        end
    end

    // R5: a recorded bus error always names a channel that raised one
    always_comb begin
        if (upd.ber) begin
            assert_ber_src_R5: assert (ev_buserr[upd.ber_ch]);
        end
    end

endmodule

// File: rtl/disp_isu_regs.sv
module disp_isu_regs
    import disp_isu_pkg::*;
#(
    parameter int ID_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  isu_upd_t        upd,
    input  logic [ID_W-1:0] id_sel,
    input  logic            wr_en,
    input  isu_sel_e        wr_sel,
    input  logic [GW-1:0]   wr_data,
    input  logic            ctl_enable,
    output logic            qd_ev,
    output logic [GW-1:0]   glb_q,
    output logic [GW-1:0]   chn_q,
    output logic [GW-1:0]   gmask_q,
    output logic [GW-1:0]   cmask_q,
    output logic [ID_W-1:0] id_q
);

    logic          en_q;
    logic [GW-1:0] g_clr;
    logic [GW-1:0] c_clr;
    logic [GW-1:0] g_nx;
    logic [GW-1:0] c_nx;

    assign qd_ev = en_q & ~ctl_enable;

    always_comb begin
        g_clr = '0;
        c_clr = '0;
        if (wr_en && wr_sel == SEL_GSTAT) g_clr = wr_data & GCLR_MASK;
        if (wr_en && wr_sel == SEL_CSTAT) c_clr = wr_data & CCLR_MASK;
        g_nx = glb_q & ~g_clr;
        if (g_clr[B_BER]) g_nx[BERCH_LO +: CH_IDX_W] = '0;
        g_nx = g_nx | upd.gset;
        if (upd.hit) g_nx[B_SUM] = 1'b1;
        if (upd.ber) g_nx[BERCH_LO +: CH_IDX_W] = upd.ber_ch;
        c_nx = (chn_q & ~c_clr) | upd.cset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            glb_q   <= '0;
            chn_q   <= '0;
            gmask_q <= '0;
            cmask_q <= '0;
            id_q    <= '0;
        end else begin
            en_q  <= ctl_enable;
            glb_q <= g_nx;
            chn_q <= c_nx;
            if (wr_en && wr_sel == SEL_GMASK) gmask_q <= wr_data & GIRQ_BITS;
            if (wr_en && wr_sel == SEL_CMASK) cmask_q <= wr_data & CVALID;
            if (upd.hit) id_q <= id_sel;
        end
    end

    assert_sticky_glb_R13: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_GSTAT) |=>
        ((glb_q & $past(glb_q) & 32'h0000_1FFF) == ($past(glb_q) & 32'h0000_1FFF)));

    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        (|upd.gset) |=> ((glb_q & $past(upd.gset)) == $past(upd.gset)));

    assert_ber_code_R5: assert property (@(posedge clk) disable iff (rst)
        upd.ber |=> (glb_q[B_BER] && glb_q[BERCH_LO +: CH_IDX_W] == $past(upd.ber_ch)));

    assert_chn_clear_scope_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CSTAT) |=>
        ((chn_q & $past(chn_q) & ~CCLR_MASK) == ($past(chn_q) & ~CCLR_MASK)));

    assert_sum_has_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(glb_q[B_SUM]) |-> $past(upd.hit));

    assert_gmask_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_GMASK) |=> $stable(gmask_q));

    assert_quick_dis_R11: assert property (@(posedge clk) disable iff (rst)
        (en_q && !ctl_enable) |=> glb_q[B_QD]);

endmodule

// File: rtl/disp_isu_irq.sv
module disp_isu_irq
    import disp_isu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [GW-1:0] glb_st,
    input  logic [GW-1:0] chn_st,
    input  logic [GW-1:0] gmask,
    input  logic [GW-1:0] cmask,
    output logic          irq_q
);

    logic g_pend;
    logic c_pend;

    assign g_pend = |(glb_st & ~gmask & GIRQ_BITS);
    assign c_pend = |(chn_st & ~cmask & CVALID);

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= g_pend | c_pend;
    end

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> ($past(|glb_st[12:0]) || $past(|chn_st)));

endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
    import disp_isu_pkg::*;
#(
    parameter int NUM_CH = 7,
    parameter int ID_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CH-1:0]      ev_sof,
    input  logic [NUM_CH-1:0]      ev_eof,
    input  logic [NUM_CH-1:0]      ev_branch,
    input  logic [NUM_CH-1:0]      ev_buserr,
    input  logic [NUM_CH-1:0]      ev_underrun,
    input  logic                   ev_last_done,
    input  logic                   ev_acb,
    input  logic                   ev_out_underrun,
    input  logic                   ev_read_stat,
    input  logic                   ev_cmd_done,
    input  logic                   ctl_enable,
    input  logic [NUM_CH*32-1:0]   ch_cmd,
    input  logic [NUM_CH*ID_W-1:0] ch_frame_id,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [31:0]            wr_data,
    output logic [31:0]            glb_status,
    output logic [31:0]            chn_status,
    output logic [ID_W-1:0]        int_id,
    output logic                   irq_o
);

    localparam int CMD_W = 32;

    isu_upd_t        upd;
    logic            qd_ev;
    logic [GW-1:0]   gmask_q;
    logic [GW-1:0]   cmask_q;
    logic [ID_W-1:0] id_sel;

    disp_isu_evmap #(.NUM_CH(NUM_CH), .CMD_W(CMD_W)) u_evmap (
        .ev_sof          (ev_sof),
        .ev_eof          (ev_eof),
        .ev_branch       (ev_branch),
        .ev_buserr       (ev_buserr),
        .ev_underrun     (ev_underrun),
        .ev_last_done    (ev_last_done),
        .ev_acb          (ev_acb),
        .ev_out_underrun (ev_out_underrun),
        .ev_read_stat    (ev_read_stat),
        .ev_cmd_done     (ev_cmd_done),
        .ev_quick_dis    (qd_ev),
        .ch_cmd          (ch_cmd),
        .gmask           (gmask_q),
        .cmask           (cmask_q),
        .upd             (upd)
    );

    always_comb begin
        id_sel = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (upd.hit_ch == CH_IDX_W'(c)) id_sel = ch_frame_id[c*ID_W +: ID_W];
        end
    end

    disp_isu_regs #(.ID_W(ID_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .upd        (upd),
        .id_sel     (id_sel),
        .wr_en      (wr_en),
        .wr_sel     (isu_sel_e'(wr_sel)),
        .wr_data    (wr_data),
        .ctl_enable (ctl_enable),
        .qd_ev      (qd_ev),
        .glb_q      (glb_status),
        .chn_q      (chn_status),
        .gmask_q    (gmask_q),
        .cmask_q    (cmask_q),
        .id_q       (int_id)
    );

    disp_isu_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .glb_st (glb_status),
        .chn_st (chn_status),
        .gmask  (gmask_q),
        .cmask  (cmask_q),
        .irq_q  (irq_o)
    );

endmodule

// File: tb/tb_disp_irq_status.sv
`timescale 1ns/1ps
module tb_disp_irq_status;

    localparam int NCH = 7;
    localparam int IDW = 32;

    logic clk = 1'b0;
    logic rst;
    logic [NCH-1:0] ev_sof, ev_eof, ev_branch, ev_buserr, ev_underrun;
    logic ev_last_done, ev_acb, ev_out_underrun, ev_read_stat, ev_cmd_done;
    logic ctl_enable;
    logic [31:0] cmd_a [NCH];
    logic [NCH*32-1:0]  ch_cmd;
    logic [NCH*IDW-1:0] ch_frame_id;
    logic wr_en;
    logic [1:0] wr_sel;
    logic [31:0] wr_data;
    logic [31:0] glb_status, chn_status;
    logic [IDW-1:0] int_id;
    logic irq_o;

    always #2 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ch_cmd[c*32 +: 32]       = cmd_a[c];
            ch_frame_id[c*IDW +: IDW] = 32'hA5A5_0000 | 32'(c);
        end
    end

    disp_irq_status #(.NUM_CH(NCH), .ID_W(IDW)) dut (
        .clk(clk), .rst(rst),
        .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_branch(ev_branch),
        .ev_buserr(ev_buserr), .ev_underrun(ev_underrun),
        .ev_last_done(ev_last_done), .ev_acb(ev_acb),
        .ev_out_underrun(ev_out_underrun), .ev_read_stat(ev_read_stat),
        .ev_cmd_done(ev_cmd_done), .ctl_enable(ctl_enable),
        .ch_cmd(ch_cmd), .ch_frame_id(ch_frame_id),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .glb_status(glb_status), .chn_status(chn_status),
        .int_id(int_id), .irq_o(irq_o)
    );

    typedef struct {
        string       tag;
        logic [31:0] g;
        logic [31:0] c;
        logic [31:0] id;
        logic        irq;
    } exp_t;

    exp_t sb_q[$];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state built from the requirements
    logic [31:0] mg, mc, mgm, mcm, mid;

    function automatic logic model_irq();
        return (|(mg & ~mgm & 32'h0000_1BFF)) || (|(mc & ~mcm & 32'h3F3F_3F3F));
    endfunction

    function automatic logic [31:0] fid(input int c);
        return 32'hA5A5_0000 | 32'(c);
    endfunction

    task automatic clear_inputs();
        ev_sof = '0; ev_eof = '0; ev_branch = '0; ev_buserr = '0; ev_underrun = '0;
        ev_last_done = 0; ev_acb = 0; ev_out_underrun = 0; ev_read_stat = 0; ev_cmd_done = 0;
        wr_en = 0; wr_sel = 2'd0; wr_data = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic push(input string tag, input logic eirq);
        exp_t e;
        e.tag = tag; e.g = mg; e.c = mc; e.id = mid; e.irq = eirq;
        sb_q.push_back(e);
    endtask

    task automatic expect_now(input string tag);
        push(tag, model_irq());
    endtask

    task automatic wreg(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
    endtask

    // monitor: compares scoreboard items shortly after each falling edge
    always @(negedge clk) begin
        #0.5;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (glb_status !== e.g || chn_status !== e.c || int_id !== e.id || irq_o !== e.irq) begin
                n_fail++;
                $display("FAIL %s: got g=%h c=%h id=%h irq=%b, expected g=%h c=%h id=%h irq=%b",
                         e.tag, glb_status, chn_status, int_id, irq_o, e.g, e.c, e.id, e.irq);
            end
        end
    end

    initial begin
        #40000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; ctl_enable = 0;
        for (int c = 0; c < NCH; c++) cmd_a[c] = 32'h0060_0000;
        clear_inputs();
        mg = '0; mc = '0; mgm = '0; mcm = '0; mid = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        settle();
        expect_now("R1 reset state");

        // channel 0 start of frame, unmasked
        ev_sof[0] = 1; tick();
        mg = 32'h0000_0402; mid = fid(0);
        push("R2 R6 ch0 sof sets bit1 and summary, R10 irq lags", 1'b0);
        settle(); expect_now("R10 irq one cycle after status");
        wreg(2'd0, 32'h0000_0402); tick();
        mg = '0;
        push("R7 clear, R10 irq still reflects prior state", 1'b1);
        settle(); expect_now("R10 irq drops after clear");

        // gating by command word
        cmd_a[3] = 32'h0020_0000;
        ev_sof[3] = 1; ev_eof[3] = 1; tick(); settle();
        mc = 32'h0000_0400; mg = 32'h0000_0400; mid = fid(3);
        expect_now("R4 ch3 sof gated off, eof at bit 10");
        wreg(2'd1, 32'h0000_0400); tick();
        wreg(2'd0, 32'h0000_0400); tick(); settle();
        mc = '0; mg = '0;
        expect_now("R4 R7 R8 cleared");
        cmd_a[3] = 32'h0060_0000;
        cmd_a[0] = 32'h0040_0000;
        ev_eof[0] = 1; tick(); settle();
        expect_now("R4 ch0 eof ignored without bit 21");
        cmd_a[0] = 32'h0060_0000;

        // packed channel positions, highest channel wins the ID
        ev_sof[1] = 1; ev_eof[6] = 1; ev_branch[2] = 1; ev_branch[1] = 1; ev_underrun[5] = 1;
        tick(); settle();
        mc = 32'h1003_2001; mg = 32'h0000_0400; mid = fid(6);
        expect_now("R3 R6 packed positions, ch6 id");
        wreg(2'd1, 32'hFFFF_FFFF); tick(); settle();
        mc = 32'h1001_0000;
        expect_now("R8 clear limited to its field");
        wreg(2'd0, 32'h0000_0400); tick(); settle();
        mg = '0;
        expect_now("R7 summary cleared, R13 channel bits kept");
        wreg(2'd3, 32'h1001_0000); tick(); settle();
        mcm = 32'h1001_0000;
        expect_now("R9 channel mask silences irq");

        // global events in one cycle
        ev_last_done = 1; ev_acb = 1; ev_out_underrun = 1; ev_read_stat = 1; ev_cmd_done = 1;
        ev_underrun[0] = 1; ev_underrun[1] = 1; ev_branch[0] = 1;
        tick(); settle();
        mg = 32'h0000_1E79; mid = fid(1);
        expect_now("R2 global bit positions");
        repeat (3) settle();
        expect_now("R13 bits stay set while idle");
        wreg(2'd0, 32'hFFFF_FFFF); tick(); settle();
        mg = 32'h0000_1000;
        expect_now("R7 bit 12 not cleared");
        wreg(2'd2, 32'hFFFF_FFFF); tick(); settle();
        mgm = 32'h0000_1BFF;
        expect_now("R9 R10 global mask silences irq");

        // masked event sets only its bit
        ev_sof[0] = 1; tick(); settle();
        mg = 32'h0000_1002;
        expect_now("R6 masked event sets no summary, id kept");
        wreg(2'd0, 32'h0000_0002); tick();
        wreg(2'd2, 32'h0000_0000); tick(); settle();
        mg = 32'h0000_1000; mgm = '0;
        expect_now("R9 R10 unmasked bit 12 drives irq");

        // bus errors
        ev_buserr[2] = 1; ev_buserr[5] = 1; tick(); settle();
        mg = 32'h5000_1404; mid = fid(5);
        expect_now("R5 bus error code is highest channel");
        wreg(2'd0, 32'h0000_0004); tick(); settle();
        mg = 32'h0000_1400;
        expect_now("R5 R7 bit 2 write clears code");
        wreg(2'd0, 32'h0000_0400); tick(); settle();
        mg = 32'h0000_1000;
        expect_now("R7 summary cleared");

        // quick disable
        ctl_enable = 1; tick(); settle();
        expect_now("R11 rising enable has no effect");
        ctl_enable = 0; tick(); settle();
        mg = 32'h0000_1080;
        expect_now("R11 falling enable sets bit 7");
        wreg(2'd0, 32'h0000_0080); tick(); settle();
        mg = 32'h0000_1000;
        expect_now("R7 quick disable cleared");

        // set wins over clear
        ev_sof[0] = 1; wreg(2'd0, 32'h0000_0002); tick(); settle();
        mg = 32'h0000_1402; mid = fid(0);
        expect_now("R12 global set beats clear");
        ev_sof[1] = 1; wreg(2'd1, 32'h0000_0001); tick(); settle();
        mc = 32'h1001_0001; mid = fid(1);
        expect_now("R12 channel set beats clear");

        settle(); settle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule